// File: doc/BRIEF.md
# Ratioed-Clock Scratchpad Store Bridge

This block takes 32-bit store requests from a processor core through a ready/valid handshake and places them on the write port of a synchronous on-chip RAM. The RAM is clocked by a divided copy of the core clock. The two clocks are phase-related, and the core clock runs at a whole-number multiple N of the RAM clock. N = 1 is the single-cycle case. Any larger N is the multi-cycle case.

The whole block runs on the core clock. A phase counter starts from a known relationship at reset. It raises `ram_phase` during the core cycle that ends on a rising edge of the RAM clock. An accepted store is held in a one-entry stage. It reaches the RAM port only on such an edge. The port then keeps address, data, enable and byte mask steady for one full RAM period, so the RAM samples them on the edge that closes that period. One idle RAM period always follows a write. Throughput is therefore capped at one store per two RAM periods, and the core is stalled through `st_ready` while the stage is occupied.

The ratio is read from `clk_ratio` during reset. A value of 0 counts as 1, and values above the maximum count as the maximum.

Top module: `ratio_store_bridge`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `st_ready` is 1, `ram_en` is 0 and `ram_we` is 0.
- R2: Core edges are numbered k = 0, 1, 2, … starting from the first edge after reset is released. With ratio N, `ram_phase` is high in the cycle before edge k exactly when k mod N equals N-1. At N = 1 it is always high.
- R3: A store is taken on an edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 from the next cycle until the store has been moved to the RAM port. No write appears on the port without a matching accepted store.
- R4: The RAM port changes only on edges that end a cycle with `ram_phase` high. At N = 1, a store accepted on edge a is loaded on edge a+1 and written by the RAM on edge a+2, so it takes three core cycles from request to completion.
- R5: At N > 1, a store accepted on edge a is loaded on the first RAM edge L ≥ a+1 that the pacing rule allows. The RAM samples it on edge L+N.
- R6: Two consecutive loads are at least 2N core edges apart, so at most one store completes every two RAM periods.
- R7: For each store, `ram_en` is high for exactly one RAM period, which is N consecutive core cycles.
- R8: `ram_we` carries the store's 4-bit byte mask while `ram_en` is high and is 0 otherwise. Bit i enables data bits 8i+7 down to 8i. A store with mask 0 still takes a slot but writes no byte.
- R9: `ram_addr` and `ram_wdata` equal the accepted store's values and hold steady for the whole RAM period in which `ram_en` is high.
- R10: The RAM contents equal the stores applied in acceptance order with their byte masks, so a later store to the same word overrides only the bytes it enables.
- R11: `clk_ratio` is read only while reset is low. Changing it after reset leaves the `ram_phase` pattern and the store timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_ratio | input | RATIO_W (4) | Core-to-RAM clock ratio, read during reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Bridge can take a store |
| st_addr | input | ADDR_W (10) | Store word address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte mask |
| ram_phase | output | 1 | High in the core cycle that ends on a RAM clock rising edge |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 4 | RAM byte write enables |
| ram_addr | output | ADDR_W (10) | RAM word address |
| ram_wdata | output | 32 | RAM write data |

## Verification
For a store accepted on edge a, `st_ready` is due low one cycle later. The write edge is due at L+N, where L is the first edge at or after a+1 that both falls on the RAM-edge phase and lies 2N or more edges after the previous load (at N = 1 this gives a+2). The bench numbers edges from reset release with its own counter and computes that schedule when each store is accepted. It samples on the falling clock edge and treats a cycle with `ram_en` and `ram_phase` both high as the RAM write. In that cycle it compares the edge number, port values and enable length. The contents of its RAM model are compared at the end of each ratio run.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;

  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef struct packed {
    logic [BE_W-1:0]   be;
    logic [WORD_W-1:0] data;
  } word_t;

  // Ratio as used by the bridge: 0 counts as 1, values above the limit saturate.
  function automatic int ratio_clamp(input int r, input int rmax);
    if (r < 1)    return 1;
    if (r > rmax) return rmax;
    return r;
  endfunction

  // Phase counter step: wraps after n-1.
  function automatic int phase_step(input int ph, input int n);
    return (ph >= n - 1) ? 0 : ph + 1;
  endfunction

  // True in the core cycle that ends on a RAM rising edge.
  function automatic bit phase_is_edge(input int ph, input int n);
    return ph == n - 1;
  endfunction

endpackage

// File: rtl/sps_phase_gen.sv
`timescale 1ns/1ps
module sps_phase_gen
  import sps_pkg::*;
#(
  parameter  int MAX_RATIO = 8,
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               phase
);

  generate
    if (MAX_RATIO == 1) begin : g_fixed
      logic unused_ok;
      assign unused_ok = ^{ratio_in, rst_n, clk};
      assign ratio_q   = RATIO_W'(1);
      assign phase     = 1'b1;
    end else begin : g_count
      logic [RATIO_W-1:0] cnt_q;
      logic [RATIO_W-1:0] n_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
          n_q   <= RATIO_W'(ratio_clamp(int'(ratio_in), MAX_RATIO));
        end else begin
          cnt_q <= RATIO_W'(phase_step(int'(cnt_q), int'(n_q)));
        end
      end

      assign ratio_q = n_q;
      assign phase   = phase_is_edge(int'(cnt_q), int'(n_q));
    end
  endgenerate

endmodule

// File: rtl/sps_intake.sv
`timescale 1ns/1ps
module sps_intake
  import sps_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  word_t             in_word,
  input  logic              take,
  output logic              in_ready,
  output logic              accept_evt,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output word_t             pend_word
);

  assign in_ready   = ~pend_valid;
  assign accept_evt = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
    end else if (accept_evt) begin
      pend_valid <= 1'b1;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_word <= '0;
    end else if (accept_evt) begin
      pend_addr <= in_addr;
      pend_word <= in_word;
    end
  end

endmodule

// File: rtl/sps_port_drv.sv
`timescale 1ns/1ps
module sps_port_drv
  import sps_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_edge,
  input  logic              pend_valid,
  input  logic [ADDR_W-1:0] pend_addr,
  input  word_t             pend_word,
  output logic              take,
  output logic              write_evt,
  output logic              ram_en,
  output logic [BE_W-1:0]   ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);

  logic              wr_active;
  logic [BE_W-1:0]   we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  // A load needs a RAM edge, a pending store and an idle period behind the last write.
  assign take      = ram_edge & pend_valid & ~wr_active;
  assign write_evt = ram_edge & wr_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      we_q      <= '0;
    end else if (ram_edge) begin
      wr_active <= take;
      we_q      <= take ? pend_word.be : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= pend_addr;
      data_q <= pend_word.data;
    end
  end

  assign ram_en    = wr_active;
  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

endmodule

// File: rtl/ratio_store_bridge.sv
`timescale 1ns/1ps
module ratio_store_bridge
  import sps_pkg::*;
#(
  parameter  int ADDR_W    = 10,
  parameter  int MAX_RATIO = 8,
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] clk_ratio,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [WORD_W-1:0]  st_data,
  input  logic [BE_W-1:0]    st_be,
  output logic               ram_phase,
  output logic               ram_en,
  output logic [BE_W-1:0]    ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [WORD_W-1:0]  ram_wdata
);

  // Named internal events, visible to the bound checker.
  logic [RATIO_W-1:0] ratio_q;
  logic               ram_edge;
  logic               accept_evt;
  logic               load_evt;
  logic               write_evt;
  logic               pend_valid;
  logic [ADDR_W-1:0]  pend_addr;
  word_t              pend_word;
  word_t              in_word;

  assign in_word.be   = st_be;
  assign in_word.data = st_data;

  sps_phase_gen #(.MAX_RATIO(MAX_RATIO)) phase_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_in (clk_ratio),
    .ratio_q  (ratio_q),
    .phase    (ram_edge)
  );

  sps_intake #(.ADDR_W(ADDR_W)) intake_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (st_valid),
    .in_addr    (st_addr),
    .in_word    (in_word),
    .take       (load_evt),
    .in_ready   (st_ready),
    .accept_evt (accept_evt),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_word  (pend_word)
  );

  sps_port_drv #(.ADDR_W(ADDR_W)) port_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_edge   (ram_edge),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_word  (pend_word),
    .take       (load_evt),
    .write_evt  (write_evt),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

  assign ram_phase = ram_edge;

endmodule

// File: rtl/sps_store_chk.sv
`timescale 1ns/1ps
module sps_store_chk #(
  parameter int ADDR_W  = 10,
  parameter int RATIO_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic               ram_edge,
  input logic [RATIO_W-1:0] ratio_q,
  input logic               load_evt,
  input logic               write_evt,
  input logic               ram_en,
  input logic [3:0]         ram_we,
  input logic [ADDR_W-1:0]  ram_addr,
  input logic [31:0]        ram_wdata
);

  logic               armed;
  logic [RATIO_W-1:0] gap_ph;
  logic [7:0]         since_ld;
  logic               seen_ld;
  logic [RATIO_W:0]   en_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      gap_ph   <= '0;
      since_ld <= '0;
      seen_ld  <= 1'b0;
      en_cnt   <= '0;
    end else begin
      armed  <= 1'b1;
      gap_ph <= ram_edge ? '0 : gap_ph + 1'b1;
      if (load_evt) begin
        since_ld <= '0;
        seen_ld  <= 1'b1;
      end else if (since_ld != 8'hFF) begin
        since_ld <= since_ld + 8'd1;
      end
      en_cnt <= ram_en ? en_cnt + 1'b1 : '0;
    end
  end

  p_phase_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_edge |-> int'(gap_ph) == int'(ratio_q) - 1);

  p_phase_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_edge |-> int'(gap_ph) < int'(ratio_q) - 1);

  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !st_ready);

  // R4 and R9: the port only moves on a RAM edge
  p_port_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(ram_edge)) |->
      ($stable(ram_en) && $stable(ram_we) && $stable(ram_addr) && $stable(ram_wdata)));

  p_load_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && seen_ld) |-> int'(since_ld) >= 2 * int'(ratio_q) - 1);

  p_en_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> int'(en_cnt) < int'(ratio_q));

  p_en_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |-> int'(en_cnt) == int'(ratio_q) - 1);

  p_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en |-> ram_we == 4'h0);

endmodule

bind ratio_store_bridge sps_store_chk #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .ram_edge  (ram_edge),
  .ratio_q   (ratio_q),
  .load_evt  (load_evt),
  .write_evt (write_evt),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata)
);

// File: tb/ratio_store_bridge_tb_top.sv
`timescale 1ns/1ps
module ratio_store_bridge_tb_top;

  localparam int AW   = 10;
  localparam int MAXR = 8;
  localparam int RW   = $clog2(MAXR + 1);
  localparam int NV   = 8;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    b;
    logic [3:0]    g;
  } vec_t;

  // address, data, byte mask, idle cycles after the store
  localparam vec_t VEC [NV] = '{
    '{10'h010, 32'h11223344, 4'hF, 4'd0},
    '{10'h011, 32'hA5A5A5A5, 4'hF, 4'd0},
    '{10'h010, 32'hDEADBEEF, 4'h3, 4'd0},
    '{10'h3FF, 32'h0BADF00D, 4'h8, 4'd3},
    '{10'h000, 32'hCAFEBABE, 4'h0, 4'd0},
    '{10'h011, 32'h55667788, 4'h6, 4'd5},
    '{10'h200, 32'h01020304, 4'hF, 4'd1},
    '{10'h200, 32'hFFFFFFFF, 4'h5, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] clk_ratio = '0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [31:0]   st_data = '0;
  logic [3:0]    st_be = '0;
  logic          ram_phase;
  logic          ram_en;
  logic [3:0]    ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0]   ram_wdata;

  ratio_store_bridge #(.ADDR_W(AW), .MAX_RATIO(MAXR)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ratio (clk_ratio),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .st_be     (st_be),
    .ram_phase (ram_phase),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  always #2.5 clk = ~clk;

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int          checks = 0;
  int          fails = 0;
  int          n_exp = 1;
  bit          mon_on = 1'b0;
  int          exp_w [NV];
  int          wi = 0;
  int          last_w = 0;
  int          en_len = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] emem [0:1023];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] m);
    logic [31:0] r = old;
    for (int j = 0; j < 4; j++)
      if (m[j]) r[8*j +: 8] = nw[8*j +: 8];
    return r;
  endfunction

  // RAM model and port monitor, sampled between clock edges
  always @(negedge clk) begin
    if (mon_on) begin
      chk(ram_phase == ((cyc % n_exp) == n_exp - 1), "R2", "ram_phase", 32'(ram_phase),
          32'((cyc % n_exp) == n_exp - 1));
      if (!ram_en) chk(ram_we == 4'h0, "R8", "we while idle", 32'(ram_we), 32'h0);
      if (ram_en && ram_phase) begin
        if (wi < NV) begin
          chk(cyc == exp_w[wi], (n_exp == 1) ? "R4" : "R5", "write edge", cyc, exp_w[wi]);
          chk(ram_addr == VEC[wi].a, "R9", "addr", 32'(ram_addr), 32'(VEC[wi].a));
          chk(ram_wdata == VEC[wi].d, "R9", "wdata", ram_wdata, VEC[wi].d);
          chk(ram_we == VEC[wi].b, "R8", "byte mask", 32'(ram_we), 32'(VEC[wi].b));
          chk(en_len + 1 == n_exp, "R7", "enable length", en_len + 1, n_exp);
          if (wi > 0) chk(cyc - last_w >= 2 * n_exp, "R6", "write spacing", cyc - last_w, 2 * n_exp);
          mem[ram_addr] = merge(mem[ram_addr], ram_wdata, ram_we);
          last_w = cyc;
          wi++;
        end else begin
          chk(1'b0, "R3", "write without store", 32'(ram_addr), 32'h0);
        end
      end
      en_len = ram_en ? en_len + 1 : 0;
    end
  end

  task automatic do_reset(input int r_in, input int n);
    mon_on   = 1'b0;
    rst_n    = 1'b0;
    st_valid = 1'b0;
    clk_ratio = RW'(r_in);
    repeat (3) @(negedge clk);
    chk(st_ready == 1'b1 && ram_en == 1'b0 && ram_we == 4'h0, "R1", "in reset",
        {29'b0, st_ready, ram_en, |ram_we}, 32'h4);
    rst_n  = 1'b1;
    n_exp  = n;
    wi     = 0;
    en_len = 0;
    last_w = 0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = '0;
      emem[i] = '0;
    end
    chk(st_ready == 1'b1 && ram_en == 1'b0 && ram_we == 4'h0, "R1", "after release",
        {29'b0, st_ready, ram_en, |ram_we}, 32'h4);
    mon_on = 1'b1;
  endtask

  task automatic run_vectors(input int n);
    int prev_l = -1000;
    for (int i = 0; i < NV; i++) begin
      int a;
      int l;
      st_valid = 1'b1;
      st_addr  = VEC[i].a;
      st_data  = VEC[i].d;
      st_be    = VEC[i].b;
      while (!st_ready) @(negedge clk);
      a = cyc;
      l = a + 1;
      if (l < prev_l + 2 * n) l = prev_l + 2 * n;
      while (l % n != n - 1) l++;
      prev_l   = l;
      exp_w[i] = l + n;
      emem[VEC[i].a] = merge(emem[VEC[i].a], VEC[i].d, VEC[i].b);
      @(negedge clk);
      st_valid = 1'b0;
      chk(!st_ready, "R3", "ready after accept", 32'(st_ready), 32'h0);
      repeat (int'(VEC[i].g)) @(negedge clk);
    end
    while (wi < NV) @(negedge clk);
    repeat (2 * n + 2) @(negedge clk);
    chk(wi == NV, "R3", "write count", wi, NV);
    for (int i = 0; i < NV; i++)
      chk(mem[VEC[i].a] == emem[VEC[i].a], "R10", "memory word", mem[VEC[i].a], emem[VEC[i].a]);
  endtask

  initial begin
    // 2:1, with the ratio input changed after reset (must be ignored)
    do_reset(2, 2);
    clk_ratio = RW'(3);
    run_vectors(2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ram_phase == ((cyc % 2) == 1), "R11", "phase after ratio change",
          32'(ram_phase), 32'((cyc % 2) == 1));
    end
    chk(mem[10'h010] == 32'h1122BEEF, "R10", "partial overwrite", mem[10'h010], 32'h1122BEEF);
    chk(mem[10'h000] == 32'h0, "R8", "empty mask writes nothing", mem[10'h000], 32'h0);
    // 1:1
    do_reset(1, 1);
    run_vectors(1);
    // 3:1
    do_reset(3, 3);
    run_vectors(3);
    // zero ratio counts as 1:1
    do_reset(0, 1);
    repeat (6) @(negedge clk);
    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule